// File: doc/BRIEF.md
# SD command completion sequencer with busy wait

This block sequences the command phase of an SD card host. Software writes a command word and pulses a start strobe. The sequencer then hands the command index to a separate command engine, and waits for that engine to report that the response has arrived. One flag in the command word decides what happens next. When the flag is set, the sequencer watches the DAT0 line. The card keeps DAT0 low for as long as it is busy, and the sequencer waits until the line returns high. When the flag is clear, the command finishes as soon as the response arrives.

Every finished command raises a completion interrupt. This includes commands that move no data, such as erase. The interrupt is a level and stays high until software acknowledges it. A programmable timeout ends a busy wait that lasts too long and flags it as an error. A response error reported by the engine also ends the command with its own flag. The DAT0 line passes through a synchronizer. The sequencer also waits a short settle period before it looks at DAT0, so a card that starts busy signalling slightly late is still caught.

Top module: `sdc_cmd_busy_ctrl`

## Requirements
- R1: When `start_i` is sampled high while the block is idle, `eng_start_o` is high for exactly one cycle after that edge. At the same edge `eng_index_o` takes `cmd_word_i[13:8]` and `busy_o` goes high.
- R2: A `start_i` pulse while `busy_o` is high is ignored: no `eng_start_o` pulse appears and `eng_index_o` keeps its value.
- R3: With `cmd_word_i[2]` = 0, the command completes on the edge that samples `rsp_done_i` high: `busy_o` falls and `irq_o` rises, whatever level DAT0 has.
- R4: With `cmd_word_i[2]` = 1, the block stays busy and holds back the interrupt for as long as DAT0 is low after the response. It completes without error within 4 cycles after DAT0 returns high. The command index has no effect on this.
- R5: With `cmd_word_i[2]` = 1, if DAT0 goes low one cycle after the response edge, the busy period is still waited out.
- R6: With `cmd_word_i[2]` = 1 and DAT0 staying high, the command completes within 4 cycles after the response edge.
- R7: If DAT0 stays low for more than `busy_tmo_i`+1 cycles of the busy phase, the command completes with `err_tmo_o` = 1.
- R8: `rsp_done_i` together with `rsp_err_i` ends the command at once with `err_rsp_o` = 1, and no busy wait follows.
- R9: `irq_o` stays high until a cycle in which `irq_ack_i` = 1. After that edge it reads 0.
- R10: If a completion and `irq_ack_i` fall on the same edge, `irq_o` stays high.
- R11: After reset, `busy_o`, `irq_o`, `eng_start_o`, `err_tmo_o` and `err_rsp_o` are all 0.
- R12: An accepted start clears `err_tmo_o` and `err_rsp_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_word_i | input | 16 | Command word: bit 2 enables the busy wait, bits 13:8 hold the command index |
| start_i | input | 1 | Start strobe |
| busy_tmo_i | input | 16 | Limit on the busy-wait timeout, in cycles |
| dat0_i | input | 1 | Sampled DAT0 line (low means the card is busy) |
| rsp_done_i | input | 1 | Response received, from the command engine |
| rsp_err_i | input | 1 | Response error, valid together with rsp_done_i |
| irq_ack_i | input | 1 | Write-1 acknowledge for the interrupt |
| eng_start_o | output | 1 | One-cycle kick to the command engine |
| eng_index_o | output | 6 | Command index for the engine |
| busy_o | output | 1 | Command or busy wait in progress |
| irq_o | output | 1 | Level-sensitive completion interrupt |
| err_tmo_o | output | 1 | Last command ended by a busy timeout |
| err_rsp_o | output | 1 | Last command ended by a response error |

## Verification
The assertions check these rules on every cycle: the engine kick lasts one cycle and appears only while busy, a start while busy produces no kick, the interrupt holds until it is acknowledged, every fall of `busy_o` comes with the interrupt high, and the two error flags never show together or during a command. Some behaviour can only be shown by the bench scenarios. These are the timing of completion relative to the response and to DAT0 with the flag set or clear, catching a late busy signal, expiry of the timeout, the command index that is handed over, and the case where an acknowledge and a completion fall on the same edge.

// File: rtl/sdc_busy_pkg.sv
package sdc_busy_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_RESP,
    ST_SETTLE,
    ST_BUSY
  } seq_state_e;

  typedef enum logic [1:0] {
    END_NONE,
    END_OK,
    END_RSP_ERR,
    END_TMO
  } end_kind_e;
endpackage

// File: rtl/sdc_bit_sync.sv
module sdc_bit_sync #(
  parameter int  STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= RESET_VAL;
        else     chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RESET_VAL}};
        else     chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/sdc_busy_timer.sv
module sdc_busy_timer #(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             run,
  input  logic [TMO_W-1:0] limit,
  output logic             expired
);
  logic [TMO_W-1:0] cnt;
  logic             sat;

  assign sat = &cnt;

  always_ff @(posedge clk) begin
    if (rst || clear)    cnt <= '0;
    else if (run && !sat) cnt <= cnt + 1'b1;
  end

  assign expired = (cnt >= limit);
endmodule

// File: rtl/sdc_irq_latch.sv
module sdc_irq_latch (
  input  logic clk,
  input  logic rst,
  input  logic raise,
  input  logic ack,
  output logic irq
);
  // raising wins over a simultaneous acknowledge
  always_ff @(posedge clk) begin
    if (rst)        irq <= 1'b0;
    else if (raise) irq <= 1'b1;
    else if (ack)   irq <= 1'b0;
  end
endmodule

// File: rtl/sdc_cmd_busy_ctrl.sv
module sdc_cmd_busy_ctrl
  import sdc_busy_pkg::*;
#(
  parameter int CMD_W       = 16,
  parameter int WAIT_BIT    = 2,
  parameter int IDX_LSB     = 8,
  parameter int IDX_W       = 6,
  parameter int TMO_W       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int SETTLE_CYC  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CMD_W-1:0] cmd_word_i,
  input  logic             start_i,
  input  logic [TMO_W-1:0] busy_tmo_i,
  input  logic             dat0_i,
  input  logic             rsp_done_i,
  input  logic             rsp_err_i,
  input  logic             irq_ack_i,
  output logic             eng_start_o,
  output logic [IDX_W-1:0] eng_index_o,
  output logic             busy_o,
  output logic             irq_o,
  output logic             err_tmo_o,
  output logic             err_rsp_o
);
  localparam int SET_W = $clog2(SETTLE_CYC + 1) + 1;
  localparam logic [SET_W-1:0] SET_LAST = SET_W'(SETTLE_CYC - 1);

  seq_state_e       state, state_nxt;
  end_kind_e        fin;
  logic             wait_flag;
  logic [SET_W-1:0] settle_cnt;
  logic             dat0_s;
  logic             tmo_exp;
  logic             accept;

  sdc_bit_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_dat0_sync (
    .clk (clk),
    .rst (rst),
    .d   (dat0_i),
    .q   (dat0_s)
  );

  sdc_busy_timer #(.TMO_W(TMO_W)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .clear   (state != ST_BUSY),
    .run     ((state == ST_BUSY) && !dat0_s),
    .limit   (busy_tmo_i),
    .expired (tmo_exp)
  );

  sdc_irq_latch u_irq (
    .clk   (clk),
    .rst   (rst),
    .raise (fin != END_NONE),
    .ack   (irq_ack_i),
    .irq   (irq_o)
  );

  assign accept = (state == ST_IDLE) && start_i;

  always_comb begin
    state_nxt = state;
    fin       = END_NONE;
    unique case (state)
      ST_IDLE:   if (start_i) state_nxt = ST_ISSUE;
      ST_ISSUE:  state_nxt = ST_RESP;
      ST_RESP: begin
        if (rsp_done_i) begin
          if (rsp_err_i) begin
            fin       = END_RSP_ERR;
            state_nxt = ST_IDLE;
          end else if (!wait_flag) begin
            fin       = END_OK;
            state_nxt = ST_IDLE;
          end else begin
            state_nxt = ST_SETTLE;
          end
        end
      end
      ST_SETTLE: if (settle_cnt == SET_LAST) state_nxt = ST_BUSY;
      ST_BUSY: begin
        if (dat0_s) begin
          fin       = END_OK;
          state_nxt = ST_IDLE;
        end else if (tmo_exp) begin
          fin       = END_TMO;
          state_nxt = ST_IDLE;
        end
      end
      default:   state_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      wait_flag   <= 1'b0;
      settle_cnt  <= '0;
      eng_start_o <= 1'b0;
      eng_index_o <= '0;
      busy_o      <= 1'b0;
      err_tmo_o   <= 1'b0;
      err_rsp_o   <= 1'b0;
    end else begin
      state       <= state_nxt;
      eng_start_o <= accept;
      busy_o      <= (state_nxt != ST_IDLE);
      if (accept) begin
        wait_flag   <= cmd_word_i[WAIT_BIT];
        eng_index_o <= cmd_word_i[IDX_LSB +: IDX_W];
        err_tmo_o   <= 1'b0;
        err_rsp_o   <= 1'b0;
      end
      if (state == ST_SETTLE) settle_cnt <= settle_cnt + 1'b1;
      else                    settle_cnt <= '0;
      if (fin == END_TMO)     err_tmo_o <= 1'b1;
      if (fin == END_RSP_ERR) err_rsp_o <= 1'b1;
    end
  end
endmodule

// File: rtl/sdc_cmd_busy_ctrl_sva.sv
module sdc_cmd_busy_ctrl_sva (
  input logic clk,
  input logic rst,
  input logic start_i,
  input logic irq_ack_i,
  input logic eng_start_o,
  input logic busy_o,
  input logic irq_o,
  input logic err_tmo_o,
  input logic err_rsp_o
);
  // R1: engine kick lasts one cycle
  a_r1_single_kick: assert property (@(posedge clk) disable iff (rst)
    eng_start_o |=> !eng_start_o);
  // R1: kick only during a command
  a_r1_kick_busy: assert property (@(posedge clk) disable iff (rst)
    eng_start_o |-> busy_o);
  // R2: start while busy gives no kick
  a_r2_start_ignored: assert property (@(posedge clk) disable iff (rst)
    (busy_o && start_i) |=> !eng_start_o);
  // R9: level held until acknowledged
  a_r9_irq_hold: assert property (@(posedge clk) disable iff (rst)
    (irq_o && !irq_ack_i) |=> irq_o);
  // R9/R10: completion always leaves the interrupt set
  a_r10_irq_on_done: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> irq_o);
  // R7/R8: error flags are exclusive
  a_r8_err_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(err_tmo_o && err_rsp_o));
  // R12: error flags never shown during a command
  a_r12_err_idle: assert property (@(posedge clk) disable iff (rst)
    (err_tmo_o || err_rsp_o) |-> !busy_o);
endmodule

bind sdc_cmd_busy_ctrl sdc_cmd_busy_ctrl_sva u_sva (
  .clk         (clk),
  .rst         (rst),
  .start_i     (start_i),
  .irq_ack_i   (irq_ack_i),
  .eng_start_o (eng_start_o),
  .busy_o      (busy_o),
  .irq_o       (irq_o),
  .err_tmo_o   (err_tmo_o),
  .err_rsp_o   (err_rsp_o)
);

// File: tb/tb_sdc_cmd_busy_ctrl.sv
module tb_sdc_cmd_busy_ctrl;
  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] cmd_word_i;
  logic        start_i;
  logic [15:0] busy_tmo_i;
  logic        dat0_i;
  logic        rsp_done_i;
  logic        rsp_err_i;
  logic        irq_ack_i;
  logic        eng_start_o;
  logic [5:0]  eng_index_o;
  logic        busy_o;
  logic        irq_o;
  logic        err_tmo_o;
  logic        err_rsp_o;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  sdc_cmd_busy_ctrl dut (
    .clk(clk), .rst(rst), .cmd_word_i(cmd_word_i), .start_i(start_i),
    .busy_tmo_i(busy_tmo_i), .dat0_i(dat0_i), .rsp_done_i(rsp_done_i),
    .rsp_err_i(rsp_err_i), .irq_ack_i(irq_ack_i), .eng_start_o(eng_start_o),
    .eng_index_o(eng_index_o), .busy_o(busy_o), .irq_o(irq_o),
    .err_tmo_o(err_tmo_o), .err_rsp_o(err_rsp_o)
  );

  task automatic chk(input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  function automatic logic [15:0] word(input int idx, input bit wait_b);
    return 16'((idx & 63) << 8) | (wait_b ? 16'h0004 : 16'h0000);
  endfunction

  // start a command; returns after the kick is visible
  task automatic issue(input int idx, input bit wait_b);
    @(negedge clk); cmd_word_i = word(idx, wait_b); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
  endtask

  // pulse response; on return the response edge has passed
  task automatic respond(input bit err);
    @(negedge clk); rsp_done_i = 1'b1; rsp_err_i = err;
    @(negedge clk); rsp_done_i = 1'b0; rsp_err_i = 1'b0;
  endtask

  task automatic ack();
    @(negedge clk); irq_ack_i = 1'b1;
    @(negedge clk); irq_ack_i = 1'b0;
  endtask

  task automatic wait_irq(input int limit, output int n);
    n = 0;
    while (!irq_o && n < limit) begin @(negedge clk); n++; end
  endtask

  task automatic t_reset();
    chk(busy_o, 0, "R11 busy after reset");
    chk(irq_o, 0, "R11 irq after reset");
    chk(eng_start_o, 0, "R11 kick after reset");
    chk(err_tmo_o | err_rsp_o, 0, "R11 errors after reset");
  endtask

  task automatic t_kick();
    issue(7, 1'b0);
    chk(eng_start_o, 1, "R1 kick high");
    chk(eng_index_o, 7, "R1 index");
    chk(busy_o, 1, "R1 busy high");
    @(negedge clk);
    chk(eng_start_o, 0, "R1 kick one cycle");
    // R2: second start while waiting for the response
    cmd_word_i = word(20, 1'b1); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    chk(eng_start_o, 0, "R2 no kick while busy");
    chk(eng_index_o, 7, "R2 index kept");
    dat0_i = 1'b0;
    respond(1'b0);
    chk(busy_o, 0, "R3 done right after response");
    chk(irq_o, 1, "R3 irq with DAT0 low");
    dat0_i = 1'b1;
    ack();
    chk(irq_o, 0, "R9 cleared by ack");
  endtask

  task automatic t_busy_wait();
    int n;
    issue(38, 1'b1); @(negedge clk);
    respond(1'b0); dat0_i = 1'b0;
    repeat (20) @(negedge clk);
    chk(busy_o, 1, "R4 still busy while DAT0 low");
    chk(irq_o, 0, "R4 no irq while DAT0 low");
    dat0_i = 1'b1;
    wait_irq(10, n);
    chk(irq_o, 1, "R4 irq after DAT0 high");
    chk(n <= 4, 1, "R4 completion latency");
    chk(err_tmo_o, 0, "R4 no timeout");
    repeat (3) @(negedge clk);
    chk(irq_o, 1, "R9 irq held without ack");
    ack();
  endtask

  task automatic t_late_busy();
    issue(12, 1'b1); @(negedge clk);
    dat0_i = 1'b1;
    respond(1'b0);
    dat0_i = 1'b0;  // card signals busy one cycle late
    repeat (12) @(negedge clk);
    chk(busy_o, 1, "R5 late busy waited");
    chk(irq_o, 0, "R5 no early irq");
    dat0_i = 1'b1;
    repeat (6) @(negedge clk);
    chk(irq_o, 1, "R5 completes after release");
    ack();
  endtask

  task automatic t_no_busy();
    int n;
    issue(41, 1'b1); @(negedge clk);
    respond(1'b0);
    wait_irq(10, n);
    chk(irq_o, 1, "R6 completes with DAT0 high");
    chk(n <= 4, 1, "R6 latency");
    ack();
  endtask

  task automatic t_timeout();
    int n;
    busy_tmo_i = 16'd10;
    issue(28, 1'b1); @(negedge clk);
    respond(1'b0); dat0_i = 1'b0;
    repeat (8) @(negedge clk);
    chk(irq_o, 0, "R7 no early timeout");
    wait_irq(40, n);
    chk(irq_o, 1, "R7 irq on timeout");
    chk(err_tmo_o, 1, "R7 timeout flag");
    chk(busy_o, 0, "R7 idle after timeout");
    dat0_i = 1'b1; busy_tmo_i = 16'd1000;
    ack();
    // R12: next accepted start clears the flag
    issue(43, 1'b0);
    chk(err_tmo_o, 0, "R12 flag cleared on start");
    @(negedge clk); respond(1'b0); ack();
  endtask

  task automatic t_rsp_err();
    issue(29, 1'b1); @(negedge clk);
    dat0_i = 1'b0;
    respond(1'b1);
    chk(busy_o, 0, "R8 ends at once");
    chk(err_rsp_o, 1, "R8 response error flag");
    chk(irq_o, 1, "R8 irq raised");
    dat0_i = 1'b1;
    ack();
  endtask

  task automatic t_ack_collide();
    issue(7, 1'b0); @(negedge clk); respond(1'b0);
    chk(irq_o, 1, "R10 first irq");
    issue(12, 1'b0); @(negedge clk);
    @(negedge clk); rsp_done_i = 1'b1; irq_ack_i = 1'b1;
    @(negedge clk); rsp_done_i = 1'b0; irq_ack_i = 1'b0;
    chk(irq_o, 1, "R10 raise wins over ack");
    ack();
    chk(irq_o, 0, "R9 cleared after collision");
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin @(posedge clk); cyc++; end
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; cmd_word_i = '0; start_i = 1'b0; busy_tmo_i = 16'd1000;
    dat0_i = 1'b1; rsp_done_i = 1'b0; rsp_err_i = 1'b0; irq_ack_i = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_kick();
    t_busy_wait();
    t_late_busy();
    t_no_busy();
    t_timeout();
    t_rsp_err();
    t_ack_collide();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule